// File: doc/BRIEF.md
# Receive Acceptance Filter and Buffer Dispatcher

This block sits between a serial bus protocol engine and a bank of message buffers. The engine hands over each decoded frame: its identifier, the extended-format and remote-request flags, the length code and up to eight data bytes. The block holds the frame in a hidden staging register. It does nothing with it until a separate valid strobe confirms that the frame was received without error.

When the valid strobe arrives, the staged identifier is compared with the stored identifier of every buffer that is configured for receive. Ordinary buffers compare under one shared global mask. One designated buffer compares under its own independent mask, so it can serve as a catch-all path for traffic that no exact-match buffer claims. The frame goes to the lowest-numbered accepting buffer, and the designated buffer is considered only after all others. The chosen buffer index, the frame fields and a write strobe are registered out to the buffer memory. The block also sets a per-buffer full flag and raises an interrupt pulse if that buffer's interrupt is enabled.

Top module: `rxf_dispatch`

## Requirements
- R1: After reset, wr_en_o and irq_o are 0 and every full_o bit is 0.
- R2: A frame is captured into staging on a cycle with frm_load_i=1. The write takes place one cycle after a cycle with frm_valid_i=1 and uses the staged frame. A load in the same cycle as the valid strobe replaces the staging only after that delivery has been taken.
- R3: A buffer accepts the frame only if its stored extended flag equals the frame's flag. In addition, every identifier bit whose mask bit is 1 must equal the stored bit, and mask bits of 0 are ignored. Extended frames compare all 29 bits. Standard frames compare only bits 10:0.
- R4: Only buffers whose buf_rx_i bit is 1 take part in acceptance.
- R5: Among the accepting buffers, the lowest index wins. The independent-mask buffer (index CATCH_IDX, default 14) wins only when no other buffer accepts.
- R6: The independent-mask buffer compares under ind_mask_i. All other buffers compare under glb_mask_i.
- R7: A valid frame that no buffer accepts produces no write and no interrupt, and it leaves full_o unchanged.
- R8: On a write, wr_idx_o, wr_id_o, wr_ide_o and wr_rtr_o carry the winner and the staged fields. wr_dlc_o is the length code capped at 8. Data byte k (bits 8k+7:8k) is passed through when k < capped length and is 0 otherwise.
- R9: full_o[i] is set in the same cycle as a write to buffer i. It is cleared by a clr_full_i[i] pulse. When a set and a clear meet in the same cycle, the set wins.
- R10: irq_o is 1 exactly in the cycle of a write whose target buffer has its irq_en_i bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_load_i | input | 1 | Capture frame fields into staging |
| frm_id_i | input | 29 | Frame identifier (standard in bits 10:0) |
| frm_ide_i | input | 1 | Frame uses extended identifier |
| frm_rtr_i | input | 1 | Frame is a remote request |
| frm_dlc_i | input | 4 | Length code |
| frm_data_i | input | 64 | Data bytes, byte k in bits 8k+7:8k |
| frm_valid_i | input | 1 | Staged frame is confirmed valid |
| buf_rx_i | input | NB | Buffer configured as receive |
| buf_id_i | input | NB*29 | Stored identifiers, buffer i in bits 29i+28:29i |
| buf_ide_i | input | NB | Stored extended flag per buffer |
| glb_mask_i | input | 29 | Global acceptance mask |
| ind_mask_i | input | 29 | Mask of the independent-mask buffer |
| irq_en_i | input | NB | Per-buffer interrupt enable |
| clr_full_i | input | NB | Per-buffer full-flag clear pulse |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_idx_o | output | 4 | Target buffer index |
| wr_id_o | output | 29 | Identifier written |
| wr_ide_o | output | 1 | Extended flag written |
| wr_rtr_o | output | 1 | Remote flag written |
| wr_dlc_o | output | 4 | Capped length written |
| wr_data_o | output | 64 | Data written, unused bytes zero |
| irq_o | output | 1 | Interrupt pulse |
| full_o | output | NB | Per-buffer full flags |

## Verification
A write that sets a buffer's full flag can land in the same cycle as a software clear of that flag. Likewise, a new frame load can coincide with the valid strobe of the frame already staged. The bench raises both on purpose. It pulses clr_full_i in the valid cycle for the buffer being targeted and expects the flag to stay set. It issues a load together with the valid strobe and expects the older frame to be delivered first and the newer one on the next strobe. A behavioural model checks every cycle, including randomized configurations that make these collisions frequent.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ID_W      = 29;
  localparam int STD_W     = 11;
  localparam int DLC_W     = 4;
  localparam int MAX_BYTES = 8;
  localparam int DATA_W    = MAX_BYTES * 8;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ide;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } rx_frame_t;
endpackage

// File: rtl/rxf_id_match.sv
module rxf_id_match
  import rxf_pkg::*;
(
  input  logic            en_i,
  input  logic [ID_W-1:0] frm_id_i,
  input  logic            frm_ide_i,
  input  logic [ID_W-1:0] ref_id_i,
  input  logic            ref_ide_i,
  input  logic [ID_W-1:0] mask_i,
  output logic            hit_o
);
  logic [ID_W-1:0] span;  // bits that exist in this frame format
  logic [ID_W-1:0] diff;

  assign span  = frm_ide_i ? {ID_W{1'b1}} : {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};
  assign diff  = (frm_id_i ^ ref_id_i) & mask_i & span;
  assign hit_o = en_i && (frm_ide_i == ref_ide_i) && (diff == '0);
endmodule

// File: rtl/rxf_first_pick.sv
module rxf_first_pick #(
  parameter int NB        = 15,
  parameter int CATCH_IDX = NB - 1,
  parameter int IW        = $clog2(NB)
) (
  input  logic [NB-1:0] hit_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // catch buffer loaded first so any ordinary hit overrides it; descending scan leaves lowest
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    if (hit_i[CATCH_IDX]) begin
      found_o = 1'b1;
      idx_o   = IW'(CATCH_IDX);
    end
    for (int i = NB - 1; i >= 0; i--) begin
      if (i != CATCH_IDX && hit_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rxf_payload_fmt.sv
module rxf_payload_fmt
  import rxf_pkg::*;
(
  input  logic [DLC_W-1:0]  dlc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DLC_W-1:0]  len_o,
  output logic [DATA_W-1:0] data_o
);
  assign len_o = (dlc_i > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc_i;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    assign data_o[8*k +: 8] = (DLC_W'(k) < len_o) ? data_i[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/rxf_dispatch.sv
module rxf_dispatch
  import rxf_pkg::*;
#(
  parameter int NB        = 15,
  parameter int CATCH_IDX = NB - 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frm_load_i,
  input  logic [ID_W-1:0]        frm_id_i,
  input  logic                   frm_ide_i,
  input  logic                   frm_rtr_i,
  input  logic [DLC_W-1:0]       frm_dlc_i,
  input  logic [DATA_W-1:0]      frm_data_i,
  input  logic                   frm_valid_i,
  input  logic [NB-1:0]          buf_rx_i,
  input  logic [NB*ID_W-1:0]     buf_id_i,
  input  logic [NB-1:0]          buf_ide_i,
  input  logic [ID_W-1:0]        glb_mask_i,
  input  logic [ID_W-1:0]        ind_mask_i,
  input  logic [NB-1:0]          irq_en_i,
  input  logic [NB-1:0]          clr_full_i,
  output logic                   wr_en_o,
  output logic [$clog2(NB)-1:0]  wr_idx_o,
  output logic [ID_W-1:0]        wr_id_o,
  output logic                   wr_ide_o,
  output logic                   wr_rtr_o,
  output logic [DLC_W-1:0]       wr_dlc_o,
  output logic [DATA_W-1:0]      wr_data_o,
  output logic                   irq_o,
  output logic [NB-1:0]          full_o
);
  localparam int IW = $clog2(NB);

  rx_frame_t stg_q;
  rx_frame_t out_q;
  logic [IW-1:0] idx_q;
  logic          wr_q, irq_q;
  logic [NB-1:0] full_q;

  // hidden staging register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else if (frm_load_i) stg_q <= '{id: frm_id_i, ide: frm_ide_i, rtr: frm_rtr_i,
                                    dlc: frm_dlc_i, data: frm_data_i};
  end

  logic [NB-1:0] hit;
  for (genvar i = 0; i < NB; i++) begin : g_buf
    logic [ID_W-1:0] mask;
    if (i == CATCH_IDX) begin : g_ind
      assign mask = ind_mask_i;
    end else begin : g_glb
      assign mask = glb_mask_i;
    end
    rxf_id_match u_match (
      .en_i      (buf_rx_i[i]),
      .frm_id_i  (stg_q.id),
      .frm_ide_i (stg_q.ide),
      .ref_id_i  (buf_id_i[i*ID_W +: ID_W]),
      .ref_ide_i (buf_ide_i[i]),
      .mask_i    (mask),
      .hit_o     (hit[i])
    );
  end

  logic          found;
  logic [IW-1:0] pick_idx;
  rxf_first_pick #(.NB(NB), .CATCH_IDX(CATCH_IDX), .IW(IW)) u_pick (
    .hit_i   (hit),
    .found_o (found),
    .idx_o   (pick_idx)
  );

  logic [DLC_W-1:0]  len;
  logic [DATA_W-1:0] dat;
  rxf_payload_fmt u_fmt (
    .dlc_i  (stg_q.dlc),
    .data_i (stg_q.data),
    .len_o  (len),
    .data_o (dat)
  );

  logic          accept;
  logic [NB-1:0] set_vec;
  assign accept  = frm_valid_i && found;
  assign set_vec = accept ? (NB'(1) << pick_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      irq_q  <= 1'b0;
      idx_q  <= '0;
      out_q  <= '0;
      full_q <= '0;
    end else begin
      wr_q   <= accept;
      irq_q  <= accept && irq_en_i[pick_idx];
      full_q <= (full_q & ~clr_full_i) | set_vec;  // set beats clear
      if (accept) begin
        idx_q <= pick_idx;
        out_q <= '{id: stg_q.id, ide: stg_q.ide, rtr: stg_q.rtr, dlc: len, data: dat};
      end
    end
  end

  assign wr_en_o   = wr_q;
  assign wr_idx_o  = idx_q;
  assign wr_id_o   = out_q.id;
  assign wr_ide_o  = out_q.ide;
  assign wr_rtr_o  = out_q.rtr;
  assign wr_dlc_o  = out_q.dlc;
  assign wr_data_o = out_q.data;
  assign irq_o     = irq_q;
  assign full_o    = full_q;
endmodule

// File: rtl/rxf_dispatch_chk.sv
module rxf_dispatch_chk
  import rxf_pkg::*;
#(
  parameter int NB        = 15,
  parameter int CATCH_IDX = NB - 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  frm_valid_i,
  input logic [NB-1:0]         buf_rx_i,
  input logic                  wr_en_o,
  input logic [$clog2(NB)-1:0] wr_idx_o,
  input logic [DLC_W-1:0]      wr_dlc_o,
  input logic                  irq_o,
  input logic [NB-1:0]         full_o
);
  assert_wr_after_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(frm_valid_i));

  assert_rx_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((($past(buf_rx_i)) >> wr_idx_o) & NB'(1)) != '0);

  assert_dlc_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_dlc_o <= DLC_W'(MAX_BYTES)));

  assert_full_on_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> full_o[wr_idx_o]);

  assert_irq_needs_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wr_en_o);

  assert_idx_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (int'(wr_idx_o) < NB));
endmodule

bind rxf_dispatch rxf_dispatch_chk #(.NB(NB), .CATCH_IDX(CATCH_IDX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frm_valid_i (frm_valid_i),
  .buf_rx_i    (buf_rx_i),
  .wr_en_o     (wr_en_o),
  .wr_idx_o    (wr_idx_o),
  .wr_dlc_o    (wr_dlc_o),
  .irq_o       (irq_o),
  .full_o      (full_o)
);

// File: tb/tb_rxf_dispatch.sv
`timescale 1ns/1ps
module tb_rxf_dispatch;
  localparam int NB = 15;
  localparam int CATCH = 14;
  localparam int IDW = 29;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic frm_load_i = 0, frm_valid_i = 0, frm_ide_i = 0, frm_rtr_i = 0;
  logic [IDW-1:0] frm_id_i = '0;
  logic [3:0] frm_dlc_i = '0;
  logic [63:0] frm_data_i = '0;
  logic [NB-1:0] buf_rx_i = '0, buf_ide_i = '0, irq_en_i = '0, clr_full_i = '0;
  logic [NB*IDW-1:0] buf_id_i = '0;
  logic [IDW-1:0] glb_mask_i = '0, ind_mask_i = '0;
  logic wr_en_o, wr_ide_o, wr_rtr_o, irq_o;
  logic [3:0] wr_idx_o, wr_dlc_o;
  logic [IDW-1:0] wr_id_o;
  logic [63:0] wr_data_o;
  logic [NB-1:0] full_o;

  rxf_dispatch dut (
    .clk_i(clk), .rst_ni(rst_n), .frm_load_i(frm_load_i), .frm_id_i(frm_id_i),
    .frm_ide_i(frm_ide_i), .frm_rtr_i(frm_rtr_i), .frm_dlc_i(frm_dlc_i),
    .frm_data_i(frm_data_i), .frm_valid_i(frm_valid_i), .buf_rx_i(buf_rx_i),
    .buf_id_i(buf_id_i), .buf_ide_i(buf_ide_i), .glb_mask_i(glb_mask_i),
    .ind_mask_i(ind_mask_i), .irq_en_i(irq_en_i), .clr_full_i(clr_full_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_id_o(wr_id_o), .wr_ide_o(wr_ide_o),
    .wr_rtr_o(wr_rtr_o), .wr_dlc_o(wr_dlc_o), .wr_data_o(wr_data_o),
    .irq_o(irq_o), .full_o(full_o));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [IDW-1:0] s_id; logic s_ide, s_rtr; logic [3:0] s_dlc; logic [63:0] s_data;
  logic e_wr, e_ide, e_rtr, e_irq; logic [3:0] e_idx, e_dlc;
  logic [IDW-1:0] e_id; logic [63:0] e_data; logic [NB-1:0] e_full;

  function automatic bit m_hit(int i);
    logic [IDW-1:0] m;
    m = (i == CATCH) ? ind_mask_i : glb_mask_i;
    if (!buf_rx_i[i]) return 0;
    if (buf_ide_i[i] != s_ide) return 0;
    for (int b = 0; b < IDW; b++)
      if ((s_ide || b < 11) && m[b] && (s_id[b] != buf_id_i[i*IDW+b])) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_id = '0; s_ide = 0; s_rtr = 0; s_dlc = '0; s_data = '0;
      e_wr = 0; e_irq = 0; e_idx = '0; e_id = '0; e_ide = 0; e_rtr = 0;
      e_dlc = '0; e_data = '0; e_full = '0;
    end else begin
      int pick;
      int n;
      pick = -1;
      if (frm_valid_i) begin
        for (int i = 0; i < NB; i++) if (i != CATCH && pick < 0 && m_hit(i)) pick = i;
        if (pick < 0 && m_hit(CATCH)) pick = CATCH;
      end
      e_full = e_full & ~clr_full_i;
      if (pick >= 0) begin
        e_wr = 1; e_idx = 4'(pick); e_id = s_id; e_ide = s_ide; e_rtr = s_rtr;
        n = (s_dlc > 8) ? 8 : int'(s_dlc);
        e_dlc = 4'(n);
        e_data = '0;
        for (int k = 0; k < n; k++) e_data[8*k +: 8] = s_data[8*k +: 8];
        e_irq = irq_en_i[pick];
        e_full[pick] = 1'b1;
      end else begin
        e_wr = 0; e_irq = 0;
      end
      if (frm_load_i) begin
        s_id = frm_id_i; s_ide = frm_ide_i; s_rtr = frm_rtr_i; s_dlc = frm_dlc_i; s_data = frm_data_i;
      end
    end
  end

  string cur = "R1";
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur, "wr_en R7", 64'(wr_en_o), 64'(e_wr));
      chk(cur, "irq R10", 64'(irq_o), 64'(e_irq));
      chk(cur, "full R9", 64'(full_o), 64'(e_full));
      if (e_wr) begin
        chk(cur, "idx R5", 64'(wr_idx_o), 64'(e_idx));
        chk(cur, "id R8", 64'(wr_id_o), 64'(e_id));
        chk(cur, "flags R8", {62'd0, wr_ide_o, wr_rtr_o}, {62'd0, e_ide, e_rtr});
        chk(cur, "dlc R8", 64'(wr_dlc_o), 64'(e_dlc));
        chk(cur, "data R8", wr_data_o, e_data);
      end
    end
  end

  task automatic load_f(logic [IDW-1:0] id, logic ide, logic rtr, logic [3:0] dlc, logic [63:0] d);
    @(negedge clk); #1;
    frm_load_i = 1; frm_id_i = id; frm_ide_i = ide; frm_rtr_i = rtr; frm_dlc_i = dlc; frm_data_i = d;
    @(negedge clk); #1;
    frm_load_i = 0;
  endtask

  // valid pulse; returns at negedge+1 with the write result on the outputs
  task automatic fire(logic [NB-1:0] clr);
    frm_valid_i = 1; clr_full_i = clr;
    @(negedge clk); #1;
    frm_valid_i = 0; clr_full_i = '0;
  endtask

  task automatic send(logic [IDW-1:0] id, logic ide);
    load_f(id, ide, 1'b0, 4'd2, 64'h1122);
    fire('0);
  endtask

  task automatic base_cfg();
    glb_mask_i = '1; ind_mask_i = '0; buf_rx_i = '1; irq_en_i = '1; buf_ide_i = '0;
    for (int i = 0; i < NB; i++) buf_id_i[i*IDW +: IDW] = (i == CATCH) ? '0 : IDW'(29'h100 + i);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "wr_en in reset", 64'(wr_en_o), 0);
    chk("R1", "full in reset", 64'(full_o), 0);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "irq after reset", 64'(irq_o), 0);
    base_cfg();

    cur = "R3"; send(29'h103, 0);
    chk("R3", "exact std idx", 64'(wr_idx_o), 3);
    chk("R3", "exact std wr", 64'(wr_en_o), 1);

    cur = "R5"; glb_mask_i = 29'h1F0; send(29'h107, 0);
    chk("R5", "lowest wins", 64'(wr_idx_o), 0);
    cur = "R4"; buf_rx_i[0] = 0; send(29'h107, 0);
    chk("R4", "tx buffer skipped", 64'(wr_idx_o), 1);

    base_cfg(); cur = "R6"; send(29'h7FF, 0);
    chk("R6", "catch path idx", 64'(wr_idx_o), CATCH);
    cur = "R7"; ind_mask_i = '1; send(29'h7FF, 0);
    chk("R7", "no match no write", 64'(wr_en_o), 0);
    chk("R7", "no match no irq", 64'(irq_o), 0);

    cur = "R3"; send(29'h103, 1);
    chk("R3", "IDE mismatch rejected", 64'(wr_en_o), 0);
    buf_ide_i[5] = 1; buf_id_i[5*IDW +: IDW] = 29'h1ABCD105;
    send(29'h1ABCD105, 1);
    chk("R3", "extended match", 64'(wr_idx_o), 5);
    send(29'h0ABCD105, 1);
    chk("R3", "extended high bit differs", 64'(wr_en_o), 0);
    send(29'h1FFFF103, 0);
    chk("R3", "std ignores bits 28:11", 64'(wr_idx_o), 3);

    base_cfg(); cur = "R8";
    load_f(29'h104, 0, 1, 4'd12, '1); fire('0);
    chk("R8", "dlc capped", 64'(wr_dlc_o), 8);
    chk("R8", "all bytes kept", wr_data_o, '1);
    chk("R8", "rtr carried", 64'(wr_rtr_o), 1);
    load_f(29'h104, 0, 0, 4'd3, '1); fire('0);
    chk("R8", "bytes past length zero", wr_data_o, 64'h0000_0000_00FF_FFFF);

    cur = "R10"; irq_en_i[3] = 0; send(29'h103, 0);
    chk("R10", "write without irq", {62'd0, wr_en_o, irq_o}, 64'b10);
    irq_en_i[3] = 1; send(29'h103, 0);
    chk("R10", "irq with write", 64'(irq_o), 1);

    cur = "R9";
    load_f(29'h103, 0, 0, 4'd1, 64'h5); fire(15'h0008);
    chk("R9", "set beats clear", 64'(full_o[3]), 1);
    clr_full_i = 15'h0008; @(negedge clk); #1 clr_full_i = '0;
    chk("R9", "clear alone", 64'(full_o[3]), 0);

    cur = "R2";
    load_f(29'h102, 0, 0, 4'd1, 64'hA);
    frm_load_i = 1; frm_id_i = 29'h106; frm_valid_i = 1;
    @(negedge clk); #1 frm_load_i = 0; frm_valid_i = 0;
    chk("R2", "older frame first", 64'(wr_idx_o), 2);
    fire('0);
    chk("R2", "newer frame next", 64'(wr_idx_o), 6);
    @(negedge clk); #1;
    chk("R2", "no write without valid", 64'(wr_en_o), 0);

    cur = "R5";
    for (int it = 0; it < 600; it++) begin
      @(negedge clk); #1;
      buf_rx_i = 15'($urandom); buf_ide_i = 15'($urandom) & 15'($urandom);
      irq_en_i = 15'($urandom);
      for (int i = 0; i < NB; i++) buf_id_i[i*IDW +: IDW] = IDW'($urandom_range(0, 15)) | (IDW'($urandom_range(0, 1)) << 20);
      glb_mask_i = IDW'($urandom) | 29'h1FFFFFF0; glb_mask_i[20] = $urandom_range(0, 1);
      ind_mask_i = IDW'($urandom) & 29'h10000F;
      frm_load_i = 1; frm_id_i = IDW'($urandom_range(0, 15)) | (IDW'($urandom_range(0, 1)) << 20) | (IDW'($urandom_range(0, 1)) << 25);
      frm_ide_i = $urandom_range(0, 3) == 0; frm_rtr_i = 1'($urandom);
      frm_dlc_i = 4'($urandom); frm_data_i = {$urandom, $urandom};
      frm_valid_i = 1'($urandom); clr_full_i = 15'($urandom) & 15'($urandom);
    end
    @(negedge clk); #1; frm_load_i = 0; frm_valid_i = 0; clr_full_i = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule